// File: doc/BRIEF.md
# Dual-mode pulse-swallow divider

This block produces the two frequencies that a frequency-synthesis loop compares. One path divides the VCO-rate clock down to the comparison rate. The other path divides the oscillator clock down to the reference rate. A phase comparator downstream consumes both pulse trains. That comparator and the charge pump that follows it are outside this block.

The VCO path reads one 16-bit programme word and interprets it according to the mode.

- **Swallow mode:** the low five bits form a swallow count `A` and the upper eleven bits form a main count `B`. A synchronous 32/33 dual-modulus prescaler, steered by the swallow count, gives a total division of 32·B + A + 32.
- **Direct mode:** the whole word `C` divides the VCO clock by C + 1, and the prescaler sits idle.

The reference path divides the oscillator by R + 1. In standby both outputs stay quiet while the clocks keep running.

Top module: `sw_dual_divider`

## Requirements
- R1: A mode value of 00 (standby) holds `syn_pulse` and `ref_pulse` low for as long as it persists.
- R2: With mode 01 or 11 (swallow), `A` = `prog_word[4:0]` and `B` = `prog_word[15:5]`. Provided B ≥ A, successive `syn_pulse` pulses are 32·B + A + 32 VCO cycles apart.
- R3: In a swallow period the prescaler counts 33 VCO cycles per output for its first A outputs and 32 for the rest. Consecutive prescaler outputs are therefore never closer than 32 cycles. With A = 0 the period is exactly 32·(B+1).
- R4: With mode 10 (direct), successive `syn_pulse` pulses are C + 1 VCO cycles apart, where C = `prog_word`. C = 0 keeps `syn_pulse` high on every cycle.
- R5: With any mode other than 00, successive `ref_pulse` pulses are R + 1 oscillator cycles apart, where R = `ref_word`.
- R6: When the period is two or more cycles, each output pulse lasts exactly one cycle of its own input clock.
- R7: A change to `prog_word` or to the mode between swallow and direct takes effect only at the next period boundary. The period already in progress completes with its old length.
- R8: While reset is asserted, and before a running mode has been selected, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO-rate clock to be divided |
| osc_clk | input | 1 | Oscillator clock for the reference path |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| div_mode | input | 2 | 00 standby, 01 AM swallow, 10 AM direct, 11 FM swallow |
| prog_word | input | 16 | Programme word: {B, A} in swallow mode, C in direct mode |
| ref_word | input | 16 | Reference divide value R |
| syn_pulse | output | 1 | One-VCO-cycle pulse per synthesis period |
| ref_pulse | output | 1 | One-oscillator-cycle pulse per reference period |

## Verification
The bench works through several corners, each of which catches a specific class of fault:

- **Smallest swallow cases (A = 0, B = 0 and B = A):** a prescaler that starts in the wrong modulus, or switches modulus one output late, is off by one in exactly these periods.
- **Short direct and reference periods, including C = 0 and R = 0:** they expose a counter that reloads with an extra idle cycle and so divides by N + 2.
- **Programme word or mode changed part-way through a period:** this catches a design that picks up new values early. Such a design would shorten or lengthen the period already under way.
- **Standby:** a divider that ignores standby would keep pulsing.

// File: rtl/sw_div_pkg.sv
package sw_div_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'b00,
    MODE_AM_SWL = 2'b01,
    MODE_AM_DIR = 2'b10,
    MODE_FM_SWL = 2'b11
  } div_mode_e;

  // Both swallow encodings share bit 0 set; direct and idle have it clear.
  function automatic logic mode_is_swallow(input logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic mode_is_running(input logic [1:0] m);
    return m != MODE_IDLE;
  endfunction

endpackage

// File: rtl/sw_reset_sync.sv
module sw_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/sw_bit_sync.sv
module sw_bit_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sw_prescaler.sv
// Synchronous dual-modulus prescaler: 2^PRE_W + 1 when mod_hi, else 2^PRE_W.
module sw_prescaler #(
  parameter int PRE_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic load,
  input  logic mod_hi,
  output logic tick
);

  localparam int CNT_W = PRE_W + 1;
  localparam logic [CNT_W-1:0] LOAD_HI = CNT_W'(1 << PRE_W);
  localparam logic [CNT_W-1:0] LOAD_LO = CNT_W'((1 << PRE_W) - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == '0);
    cnt_d = cnt_q;
    if (load || tick) cnt_d = mod_hi ? LOAD_HI : LOAD_LO;
    else if (en)      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sw_vco_divider.sv
module sw_vco_divider #(
  parameter int PROG_W = 16,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              mode_swl,
  input  logic [PROG_W-1:0] prog_word,
  output logic              pulse
);

  localparam int B_W = PROG_W - PRE_W;

  logic              primed_q, primed_d;
  logic              act_swl_q, act_swl_d;
  logic [PRE_W-1:0]  a_cnt, a_d;
  logic [B_W-1:0]    b_cnt, b_d;
  logic [PROG_W-1:0] c_cnt, c_d;

  logic pre_tick, pre_en, mod_hi;
  logic swl_end, dir_end, end_evt, reload;

  always_comb begin
    pre_en  = run && primed_q && act_swl_q;
    swl_end = pre_tick && (b_cnt == '0);
    dir_end = (c_cnt == '0);
    end_evt = run && primed_q && (act_swl_q ? swl_end : dir_end);
    reload  = run && (!primed_q || end_evt);
  end

  always_comb begin
    primed_d  = primed_q;
    act_swl_d = act_swl_q;
    a_d       = a_cnt;
    b_d       = b_cnt;
    c_d       = c_cnt;
    if (!run) begin
      primed_d = 1'b0;
    end else if (reload) begin
      primed_d  = 1'b1;
      act_swl_d = mode_swl;
      a_d       = prog_word[PRE_W-1:0];
      b_d       = prog_word[PROG_W-1:PRE_W];
      c_d       = prog_word;
    end else if (act_swl_q) begin
      if (pre_tick) begin
        b_d = b_cnt - 1'b1;
        a_d = (a_cnt != '0) ? a_cnt - 1'b1 : a_cnt;
      end
    end else begin
      c_d = c_cnt - 1'b1;
    end
    mod_hi = (a_d != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      act_swl_q <= 1'b0;
      a_cnt     <= '0;
      b_cnt     <= '0;
      c_cnt     <= '0;
    end else begin
      primed_q  <= primed_d;
      act_swl_q <= act_swl_d;
      a_cnt     <= a_d;
      b_cnt     <= b_d;
      c_cnt     <= c_d;
    end
  end

  sw_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (pre_en),
    .load   (reload),
    .mod_hi (mod_hi),
    .tick   (pre_tick)
  );

  assign pulse = end_evt;

endmodule

// File: rtl/sw_ref_divider.sv
module sw_ref_divider #(
  parameter int REF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [REF_W-1:0] ref_word,
  output logic             pulse
);

  logic             primed_q, primed_d;
  logic [REF_W-1:0] r_cnt, r_d;
  logic             end_evt, reload;

  always_comb begin
    end_evt  = run && primed_q && (r_cnt == '0);
    reload   = run && (!primed_q || end_evt);
    primed_d = primed_q;
    r_d      = r_cnt;
    if (!run) begin
      primed_d = 1'b0;
    end else if (reload) begin
      primed_d = 1'b1;
      r_d      = ref_word;
    end else begin
      r_d = r_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      r_cnt    <= '0;
    end else begin
      primed_q <= primed_d;
      r_cnt    <= r_d;
    end
  end

  assign pulse = end_evt;

endmodule

// File: rtl/sw_dual_divider.sv
module sw_dual_divider #(
  parameter int PROG_W      = 16,
  parameter int PRE_W       = 5,
  parameter int REF_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              vco_clk,
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic [1:0]        div_mode,
  input  logic [PROG_W-1:0] prog_word,
  input  logic [REF_W-1:0]  ref_word,
  output logic              syn_pulse,
  output logic              ref_pulse
);

  import sw_div_pkg::*;

  logic       vco_srst_n, osc_srst_n;
  logic [1:0] vco_mode, ref_mode;
  logic       vco_run, vco_swl, ref_run;

  sw_reset_sync #(.STAGES(SYNC_STAGES)) u_vco_rst (
    .clk(vco_clk), .arst_n(rst_n), .srst_n(vco_srst_n));

  sw_reset_sync #(.STAGES(SYNC_STAGES)) u_osc_rst (
    .clk(osc_clk), .arst_n(rst_n), .srst_n(osc_srst_n));

  sw_bit_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_vco_mode (
    .clk(vco_clk), .rst_n(vco_srst_n), .d(div_mode), .q(vco_mode));

  sw_bit_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_osc_mode (
    .clk(osc_clk), .rst_n(osc_srst_n), .d(div_mode), .q(ref_mode));

  assign vco_run = mode_is_running(vco_mode);
  assign vco_swl = mode_is_swallow(vco_mode);
  assign ref_run = mode_is_running(ref_mode);

  sw_vco_divider #(.PROG_W(PROG_W), .PRE_W(PRE_W)) u_vco (
    .clk       (vco_clk),
    .rst_n     (vco_srst_n),
    .run       (vco_run),
    .mode_swl  (vco_swl),
    .prog_word (prog_word),
    .pulse     (syn_pulse)
  );

  sw_ref_divider #(.REF_W(REF_W)) u_ref (
    .clk      (osc_clk),
    .rst_n    (osc_srst_n),
    .run      (ref_run),
    .ref_word (ref_word),
    .pulse    (ref_pulse)
  );

endmodule

// File: rtl/sw_dual_divider_chk.sv
module sw_dual_divider_chk #(
  parameter int PRE_W = 5
) (
  input logic             vco_clk,
  input logic             osc_clk,
  input logic             vco_rst_n,
  input logic             osc_rst_n,
  input logic             vco_run,
  input logic             ref_run,
  input logic             syn_pulse,
  input logic             ref_pulse,
  input logic             pre_tick,
  input logic             pre_en,
  input logic             reload,
  input logic [PRE_W-1:0] a_cnt
);

  // R1: no synthesis pulse while the VCO domain sees standby
  p_syn_quiet_r1: assert property (@(posedge vco_clk) disable iff (!vco_rst_n)
    !vco_run |-> !syn_pulse);

  // R1: no reference pulse while the oscillator domain sees standby
  p_ref_quiet_r1: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    !ref_run |-> !ref_pulse);

  // R3: prescaler outputs are never on adjacent cycles
  p_pre_spacing_r3: assert property (@(posedge vco_clk) disable iff (!vco_rst_n)
    pre_tick |=> !pre_tick);

  // R3: once the swallow count is spent it stays spent until a reload
  p_swallow_spent_r3: assert property (@(posedge vco_clk) disable iff (!vco_rst_n)
    (pre_en && (a_cnt == '0) && !reload) |=> (a_cnt == '0));

endmodule

bind sw_dual_divider sw_dual_divider_chk #(.PRE_W(PRE_W)) u_chk (
  .vco_clk   (vco_clk),
  .osc_clk   (osc_clk),
  .vco_rst_n (vco_srst_n),
  .osc_rst_n (osc_srst_n),
  .vco_run   (vco_run),
  .ref_run   (ref_run),
  .syn_pulse (syn_pulse),
  .ref_pulse (ref_pulse),
  .pre_tick  (u_vco.pre_tick),
  .pre_en    (u_vco.pre_en),
  .reload    (u_vco.reload),
  .a_cnt     (u_vco.a_cnt)
);

// File: tb/test_sw_dual_divider.sv
module test_sw_dual_divider;

  logic        vco_clk = 1'b0;
  logic        osc_clk = 1'b0;
  logic        rst_n;
  logic [1:0]  div_mode;
  logic [15:0] prog_word;
  logic [15:0] ref_word;
  logic        syn_pulse, ref_pulse;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 vco_clk = ~vco_clk;  // 250 MHz
  always #3 osc_clk = ~osc_clk;

  sw_dual_divider i_sw_dual_divider (
    .vco_clk   (vco_clk),
    .osc_clk   (osc_clk),
    .rst_n     (rst_n),
    .div_mode  (div_mode),
    .prog_word (prog_word),
    .ref_word  (ref_word),
    .syn_pulse (syn_pulse),
    .ref_pulse (ref_pulse)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Waits for a pulse, then counts VCO cycles to the next one.
  task automatic meas_syn(output int per, output int after);
    int g = 0;
    per = -1;
    after = 1;
    do begin @(negedge vco_clk); g++; end while (!syn_pulse && g < 80000);
    if (!syn_pulse) return;
    per = 0;
    do begin
      @(negedge vco_clk);
      per++;
      if (per == 1) after = int'(syn_pulse);
    end while (!syn_pulse && per < 80000);
    if (!syn_pulse) per = -1;
  endtask

  task automatic meas_ref(output int per, output int after);
    int g = 0;
    per = -1;
    after = 1;
    do begin @(negedge osc_clk); g++; end while (!ref_pulse && g < 80000);
    if (!ref_pulse) return;
    per = 0;
    do begin
      @(negedge osc_clk);
      per++;
      if (per == 1) after = int'(ref_pulse);
    end while (!ref_pulse && per < 80000);
    if (!ref_pulse) per = -1;
  endtask

  task automatic run_syn(input logic [1:0] m, input int word, input int exp, input string req);
    int p;
    int a;
    div_mode  = m;
    prog_word = 16'(word);
    meas_syn(p, a);
    meas_syn(p, a);
    meas_syn(p, a);
    check(req, p, exp);
    if (exp > 1) check("R6 syn width", a, 0);
  endtask

  task automatic run_ref(input int r);
    int p;
    int a;
    ref_word = 16'(r);
    meas_ref(p, a);
    meas_ref(p, a);
    meas_ref(p, a);
    check("R5 ref period", p, r + 1);
    if (r > 0) check("R6 ref width", a, 0);
  endtask

  initial begin
    repeat (200000) @(posedge vco_clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sa [9] = '{0, 0, 1, 2, 5, 15, 31, 3, 31};
    int sb [9] = '{0, 1, 1, 2, 5, 15, 31, 7, 40};
    int p;
    int a;
    int cnt_s;
    int cnt_r;

    rst_n     = 1'b0;
    div_mode  = 2'b01;
    prog_word = 16'd100;
    ref_word  = 16'd5;
    repeat (5) @(negedge vco_clk);
    // R8: outputs low while reset is held
    check("R8 syn in reset", int'(syn_pulse), 0);
    check("R8 ref in reset", int'(ref_pulse), 0);
    div_mode = 2'b00;
    rst_n = 1'b1;
    repeat (10) @(negedge vco_clk);
    check("R8 syn after reset idle", int'(syn_pulse), 0);
    check("R8 ref after reset idle", int'(ref_pulse), 0);

    // R2 / R3: swallow periods, A = 0 and B = A included
    for (int i = 0; i < 9; i++) begin
      run_syn((i % 2) ? 2'b11 : 2'b01, (sb[i] << 5) | sa[i],
              32 * sb[i] + sa[i] + 32,
              (sa[i] == 0) ? "R3 swallow A=0" : "R2 swallow period");
    end

    // R4: direct sweep and a long value
    for (int c = 0; c < 24; c++) run_syn(2'b10, c, c + 1, "R4 direct period");
    run_syn(2'b10, 3000, 3001, "R4 direct long");
    // R4: C = 0 keeps the output high
    div_mode = 2'b10;
    prog_word = 16'd0;
    repeat (10) @(negedge vco_clk);
    cnt_s = 0;
    for (int k = 0; k < 20; k++) begin @(negedge vco_clk); cnt_s += int'(syn_pulse); end
    check("R4 direct C=0 level", cnt_s, 20);

    // R5: reference sweep (mode running)
    div_mode = 2'b01;
    for (int r = 0; r < 17; r++) run_ref(r);
    run_ref(500);

    // R7: word change in the middle of a direct period
    run_syn(2'b10, 40, 41, "R4 direct period");
    meas_syn(p, a);
    repeat (10) @(negedge vco_clk);
    prog_word = 16'd7;
    p = 10;
    do begin @(negedge vco_clk); p++; end while (!syn_pulse && p < 5000);
    check("R7 period in progress kept", p, 41);
    meas_syn(p, a);
    check("R7 new word next period", p, 8);

    // R7: mode change swallow -> direct mid-period (A=1, B=1 -> 65; C=33 -> 34)
    run_syn(2'b01, 33, 65, "R2 swallow period");
    meas_syn(p, a);
    repeat (5) @(negedge vco_clk);
    div_mode = 2'b10;
    p = 5;
    do begin @(negedge vco_clk); p++; end while (!syn_pulse && p < 5000);
    check("R7 mode change waits", p, 65);
    meas_syn(p, a);
    check("R7 direct after switch", p, 34);

    // R1: standby silences both outputs
    div_mode = 2'b00;
    prog_word = 16'd3;
    ref_word = 16'd2;
    repeat (8) @(negedge vco_clk);
    cnt_s = 0;
    cnt_r = 0;
    fork
      for (int k = 0; k < 400; k++) begin @(negedge vco_clk); cnt_s += int'(syn_pulse); end
      for (int k = 0; k < 300; k++) begin @(negedge osc_clk); cnt_r += int'(ref_pulse); end
    join
    check("R1 syn standby", cnt_s, 0);
    check("R1 ref standby", cnt_r, 0);

    // R1: leaving standby restarts both dividers
    run_syn(2'b11, (2 << 5) | 1, 97, "R2 swallow after standby");
    run_ref(2);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule